// File: doc/BRIEF.md
# Prescaled Message Timestamp Timer

This block keeps a free-running time base for a message controller. The I/O clock first passes a fixed divide-by-eight stage and then a programmable divider of 8 bits. The resulting tick advances a wrapping counter. The counter runs only while the controller is switched on. It restarts from zero each time the controller is switched on again. When it wraps, it raises a sticky overflow flag that software clears by writing a one.

Each message object has a stamp register. The stamp register takes a copy of the time base when its object reports a finished transmission or a finished reception. This gives software a time for every message. A further sync register supports time-triggered operation. It takes a copy of the time base at the start or at the end of a frame, as a select bit chooses, but only while time-triggered operation is on. While that mode is on, the block also tells the frame engine not to retry a failed frame.

Top module: `msg_stamp_timer`

## Requirements
- R1: With divider value N, the time base advances once every 8*(N+1) clock cycles. After m rising edges with the controller enabled, counted from a zero time base, `timer_val` equals floor(m / (8*(N+1))) modulo 2^TMR_W.
- R2: While `ctl_en` is low, the prescaler and the time base are forced to zero on the next edge. After `ctl_en` rises, counting restarts from zero.
- R3: A write on `psc_wr` takes effect at the next terminal count of the programmable divider. While `ctl_en` is low, the written value is applied within one further cycle.
- R4: The time base steps by exactly one per tick and wraps from all ones to zero.
- R5: `ovf_flag` is set on the edge where the time base wraps from all ones to zero. It then stays set, also while `ctl_en` is low, until an `ovf_clr` pulse clears it. If the wrap and the clear fall on the same edge, the set wins.
- R6: Object i's stamp (`stamp_flat[i*TMR_W +: TMR_W]`) loads `timer_val` on an edge where `tx_ok[i]` or `rx_ok[i]` is high. If the time base advances on that same edge, the stamp holds the value from before the advance. Stamps of objects without a strobe are unchanged.
- R7: While `tt_mode` is 1, `sync_val` loads `timer_val` on `sof_pulse` when `sync_sel` is 0, and on `eof_pulse` when `sync_sel` is 1. The edge that is not selected, and any strobe while `tt_mode` is 0, leave `sync_val` unchanged.
- R8: `no_retry` is 1 exactly while `tt_mode` is 1.
- R9: After reset, `timer_val`, `ovf_flag`, `sync_val` and every stamp read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable; runs the prescaler and the time base |
| psc_wr | input | 1 | Strobe to write the divider value |
| psc_wdata | input | PSC_W | Divider value N |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| tt_mode | input | 1 | Time-triggered mode |
| sync_sel | input | 1 | Sync capture edge: 0 start of frame, 1 end of frame |
| sof_pulse | input | 1 | Start-of-frame strobe |
| eof_pulse | input | 1 | End-of-frame strobe |
| tx_ok | input | NUM_OBJ | Per-object transmit-done strobes |
| rx_ok | input | NUM_OBJ | Per-object receive-done strobes |
| timer_val | output | TMR_W | Current time base |
| ovf_flag | output | 1 | Sticky wrap flag |
| sync_val | output | TMR_W | Sync capture register |
| stamp_flat | output | NUM_OBJ*TMR_W | Per-object stamps, object 0 in the low bits |
| no_retry | output | 1 | Suppresses automatic retransmission |

## Verification
Some properties are checked on every cycle. The time base clears while disabled and never moves by more than one step. The overflow flag is set on a wrap and stays set until a clear. Every stamp and the sync register copy the prior time base on their strobe and hold otherwise.

Other behaviour can only be shown by the bench's scenarios. These are the exact tick period for each divider value, the edge where a new divider value takes effect, the set-over-clear priority, and the sync edge selection. The bench derives the expected values from cycle counts.

// File: rtl/msg_stamp_pkg.sv
package msg_stamp_pkg;
  localparam int unsigned FIXED_DIV = 8;

  typedef enum logic {
    SYNC_AT_SOF = 1'b0,
    SYNC_AT_EOF = 1'b1
  } sync_edge_e;
endpackage

// File: rtl/mst_rst_sync.sv
module mst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/mst_prescaler.sv
module mst_prescaler #(
  parameter int unsigned PSC_W   = 8,
  parameter int unsigned FIX_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr,
  input  logic [PSC_W-1:0] wdata,
  output logic             tick
);
  localparam int unsigned FW = (FIX_DIV > 2) ? $clog2(FIX_DIV) : 1;
  localparam logic [FW-1:0] FIX_LAST = FW'(FIX_DIV - 1);

  logic [FW-1:0]    fix_q, fix_d;
  logic [PSC_W-1:0] pcnt_q, pcnt_d;
  logic [PSC_W-1:0] pend_q, act_q;
  logic             pend_en, act_en, fix_end;

  // fixed stage end and programmable terminal count
  always_comb begin
    fix_end = run && (fix_q == FIX_LAST);
    tick    = fix_end && (pcnt_q == act_q);

    if (!run)        fix_d = '0;
    else if (fix_end) fix_d = '0;
    else             fix_d = fix_q + 1'b1;

    if (!run || tick) pcnt_d = '0;
    else if (fix_end) pcnt_d = pcnt_q + 1'b1;
    else              pcnt_d = pcnt_q;

    pend_en = wr;
    act_en  = !run || tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q  <= '0;
      pcnt_q <= '0;
    end else begin
      fix_q  <= fix_d;
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= pend_q;
  end
endmodule

// File: rtl/mst_counter.sv
module mst_counter #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] count,
  output logic             ovf
);
  logic [TMR_W-1:0] cnt_d;
  logic             ovf_d, wrap;

  always_comb begin
    wrap = run && tick && (count == {TMR_W{1'b1}});
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = count + 1'b1;
    else           cnt_d = count;

    if (wrap)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= cnt_d;
      ovf   <= ovf_d;
    end
  end
endmodule

// File: rtl/mst_capture.sv
module mst_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/msg_stamp_timer.sv
module msg_stamp_timer
  import msg_stamp_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 6,
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned PSC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_en,
  input  logic                     psc_wr,
  input  logic [PSC_W-1:0]         psc_wdata,
  input  logic                     ovf_clr,
  input  logic                     tt_mode,
  input  logic                     sync_sel,
  input  logic                     sof_pulse,
  input  logic                     eof_pulse,
  input  logic [NUM_OBJ-1:0]       tx_ok,
  input  logic [NUM_OBJ-1:0]       rx_ok,
  output logic [TMR_W-1:0]         timer_val,
  output logic                     ovf_flag,
  output logic [TMR_W-1:0]         sync_val,
  output logic [NUM_OBJ*TMR_W-1:0] stamp_flat,
  output logic                     no_retry
);
  logic rst_n_i;
  logic tick;
  logic sync_load;
  sync_edge_e sync_edge;

  mst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  mst_prescaler #(.PSC_W(PSC_W), .FIX_DIV(FIXED_DIV)) u_psc (
    .clk   (clk),
    .rst_n (rst_n_i),
    .run   (ctl_en),
    .wr    (psc_wr),
    .wdata (psc_wdata),
    .tick  (tick)
  );

  mst_counter #(.TMR_W(TMR_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .run     (ctl_en),
    .tick    (tick),
    .ovf_clr (ovf_clr),
    .count   (timer_val),
    .ovf     (ovf_flag)
  );

  always_comb begin
    sync_edge = sync_edge_e'(sync_sel);
    sync_load = tt_mode && ((sync_edge == SYNC_AT_EOF) ? eof_pulse : sof_pulse);
  end

  mst_capture #(.W(TMR_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (sync_load),
    .din   (timer_val),
    .dout  (sync_val)
  );

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
    mst_capture #(.W(TMR_W)) u_stamp (
      .clk   (clk),
      .rst_n (rst_n_i),
      .load  (tx_ok[i] | rx_ok[i]),
      .din   (timer_val),
      .dout  (stamp_flat[i*TMR_W +: TMR_W])
    );
  end

  assign no_retry = tt_mode;
endmodule

// File: rtl/msg_stamp_timer_chk.sv
module msg_stamp_timer_chk #(
  parameter int unsigned NUM_OBJ = 6,
  parameter int unsigned TMR_W   = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ctl_en,
  input logic                     ovf_clr,
  input logic                     tt_mode,
  input logic                     sync_sel,
  input logic                     sof_pulse,
  input logic                     eof_pulse,
  input logic [NUM_OBJ-1:0]       tx_ok,
  input logic [NUM_OBJ-1:0]       rx_ok,
  input logic [TMR_W-1:0]         timer_val,
  input logic                     ovf_flag,
  input logic [TMR_W-1:0]         sync_val,
  input logic [NUM_OBJ*TMR_W-1:0] stamp_flat
);
  a_r2_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (timer_val == '0));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en |=> (timer_val == $past(timer_val) ||
                timer_val == TMR_W'($past(timer_val) + 1'b1)));

  a_r5_set_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && $past(ctl_en) && $past(timer_val) == {TMR_W{1'b1}} &&
     timer_val == '0) |-> ovf_flag);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r7_sync_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (tt_mode && !sync_sel && sof_pulse) |=> (sync_val == $past(timer_val)));

  a_r7_sync_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (tt_mode && sync_sel && eof_pulse) |=> (sync_val == $past(timer_val)));

  a_r7_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tt_mode |=> $stable(sync_val));

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_chk
    a_r6_stamp_load: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ok[g] || rx_ok[g]) |=> (stamp_flat[g*TMR_W +: TMR_W] == $past(timer_val)));

    a_r6_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_ok[g] || rx_ok[g]) |=> $stable(stamp_flat[g*TMR_W +: TMR_W]));
  end
endmodule

bind msg_stamp_timer msg_stamp_timer_chk #(.NUM_OBJ(NUM_OBJ), .TMR_W(TMR_W)) u_chk (.*);

// File: tb/msg_stamp_timer_bench.sv
module msg_stamp_timer_bench;
  localparam int NOBJ = 4;
  localparam int TW   = 8;
  localparam int PW   = 8;

  logic clk = 1'b0;
  logic rst_n, ctl_en, psc_wr, ovf_clr, tt_mode, sync_sel, sof_pulse, eof_pulse;
  logic [PW-1:0]      psc_wdata;
  logic [NOBJ-1:0]    tx_ok, rx_ok;
  logic [TW-1:0]      timer_val, sync_val;
  logic               ovf_flag, no_retry;
  logic [NOBJ*TW-1:0] stamp_flat;

  int checks = 0;
  int failures = 0;
  int ecnt = 0;
  int exp_stamp [NOBJ];
  int exp_sync = 0;

  always #10 clk = ~clk;

  msg_stamp_timer #(.NUM_OBJ(NOBJ), .TMR_W(TW), .PSC_W(PW)) u_msg_stamp_timer (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .psc_wr(psc_wr), .psc_wdata(psc_wdata),
    .ovf_clr(ovf_clr), .tt_mode(tt_mode), .sync_sel(sync_sel), .sof_pulse(sof_pulse),
    .eof_pulse(eof_pulse), .tx_ok(tx_ok), .rx_ok(rx_ok), .timer_val(timer_val),
    .ovf_flag(ovf_flag), .sync_val(sync_val), .stamp_flat(stamp_flat), .no_retry(no_retry)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    ecnt += n;
  endtask

  task automatic restart(input int n);
    ctl_en = 1'b0; psc_wr = 1'b1; psc_wdata = PW'(n);
    step(1);
    psc_wr = 1'b0;
    step(1);
    ctl_en = 1'b1;
    ecnt = 0;
  endtask

  task automatic clear_ovf();
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
  endtask

  function automatic int stamp_of(input int i);
    return int'(stamp_flat[i*TW +: TW]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_en = 1'b0; psc_wr = 1'b0; psc_wdata = '0; ovf_clr = 1'b0;
    tt_mode = 1'b0; sync_sel = 1'b0; sof_pulse = 1'b0; eof_pulse = 1'b0;
    tx_ok = '0; rx_ok = '0;
    for (int i = 0; i < NOBJ; i++) exp_stamp[i] = 0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R9 reset state
    chk("R9 timer", timer_val, 0);
    chk("R9 ovf", ovf_flag, 0);
    chk("R9 sync", sync_val, 0);
    for (int i = 0; i < NOBJ; i++) chk("R9 stamp", stamp_of(i), 0);

    // R1 period sweep over several divider values
    foreach (exp_stamp[k]) begin end
    for (int s = 0; s < 4; s++) begin
      int n;
      n = (s == 3) ? 5 : s;
      restart(n);
      for (int m = 1; m <= 160; m++) begin
        step(1);
        chk("R1 period", timer_val, (m / (8 * (n + 1))) % 256);
      end
    end

    // R2 disable clears, restart counts from zero (divider still 5)
    ctl_en = 1'b0; step(1);
    chk("R2 cleared", timer_val, 0);
    ctl_en = 1'b1; step(47);
    chk("R2 restart before tick", timer_val, 0);
    step(1);
    chk("R2 restart first tick", timer_val, 1);

    // R3 divider write applies at next terminal count
    restart(0);
    step(4);
    psc_wr = 1'b1; psc_wdata = 8'd3; step(1); psc_wr = 1'b0;
    for (int m = 6; m <= 80; m++) begin
      step(1);
      chk("R3 new divider", timer_val, (m < 8) ? 0 : 1 + (m - 8) / 32);
    end

    // R4 and R5 wrap and overflow flag
    restart(0);
    clear_ovf();
    step(2046);
    chk("R4 before wrap", timer_val, 255);
    chk("R5 no flag yet", ovf_flag, 0);
    step(1);
    chk("R4 wrapped", timer_val, 0);
    chk("R5 flag set", ovf_flag, 1);
    step(100);
    chk("R5 flag held", ovf_flag, 1);
    ctl_en = 1'b0; step(5);
    chk("R5 held while off", ovf_flag, 1);
    clear_ovf();
    chk("R5 cleared", ovf_flag, 0);
    restart(0);
    step(2047);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R5 set wins over clear", ovf_flag, 1);
    clear_ovf();
    chk("R5 cleared after", ovf_flag, 0);

    // R6 per-object stamps
    restart(0);
    for (int i = 0; i < NOBJ; i++) begin
      for (int r = 0; r < 2; r++) begin
        int k;
        k = (r == 0) ? 3 : 7 + i;
        step(k);
        if ((i + r) % 2 == 0) tx_ok[i] = 1'b1; else rx_ok[i] = 1'b1;
        exp_stamp[i] = (ecnt / 8) % 256;
        step(1);
        tx_ok = '0; rx_ok = '0;
        for (int j = 0; j < NOBJ; j++) chk("R6 stamp", stamp_of(j), exp_stamp[j]);
      end
    end
    while ((ecnt + 1) % 8 != 0) step(1);
    tx_ok[1] = 1'b1; rx_ok[2] = 1'b1;
    exp_stamp[1] = (ecnt / 8) % 256; exp_stamp[2] = exp_stamp[1];
    step(1);
    tx_ok = '0; rx_ok = '0;
    for (int j = 0; j < NOBJ; j++) chk("R6 stamp on tick edge", stamp_of(j), exp_stamp[j]);

    // R7 sync capture and R8 retry suppression
    restart(0);
    chk("R8 off", no_retry, 0);
    step(20);
    sof_pulse = 1'b1; eof_pulse = 1'b1; step(1); sof_pulse = 1'b0; eof_pulse = 1'b0;
    chk("R7 ignored without mode", sync_val, exp_sync);
    tt_mode = 1'b1; sync_sel = 1'b0;
    step(1);
    chk("R8 on", no_retry, 1);
    step(10);
    eof_pulse = 1'b1; step(1); eof_pulse = 1'b0;
    chk("R7 eof ignored when sof selected", sync_val, exp_sync);
    step(6);
    sof_pulse = 1'b1; exp_sync = (ecnt / 8) % 256; step(1); sof_pulse = 1'b0;
    chk("R7 sof capture", sync_val, exp_sync);
    sync_sel = 1'b1; step(13);
    sof_pulse = 1'b1; step(1); sof_pulse = 1'b0;
    chk("R7 sof ignored when eof selected", sync_val, exp_sync);
    step(9);
    eof_pulse = 1'b1; exp_sync = (ecnt / 8) % 256; step(1); eof_pulse = 1'b0;
    chk("R7 eof capture", sync_val, exp_sync);
    tt_mode = 1'b0; step(1);
    chk("R8 off again", no_retry, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule